// File: doc/BRIEF.md
# Five-Mode Operand Fetch Unit

This unit turns the 13-bit operand field of an instruction into a 24-bit operand value. A start pulse comes with a 3-bit mode code and the field. The unit then does one of five things. It can sign-extend the field as a constant. It can read one memory word, or chase one memory word through a second read. It can return the contents of a register, or use that register as a memory pointer. The five architectural registers (accumulator, three general registers and the program counter) are inputs to the unit. Memory is reached through a synchronous read port that has one cycle of latency.

When the operand is ready, the unit raises `done` for one cycle and presents the value. It asserts `err` with a zero operand when the mode code or the register code is undefined. The unit accepts one request at a time. While `busy` is high, any further start pulse is dropped.

Top module: `opnd_fetch`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `mem_rd_en` are low and `operand` is zero.
- R2: Mode 0 (constant) returns the 13-bit field sign-extended to 24 bits, with `done` high in the first cycle after the start edge and no memory read.
- R3: Mode 1 (direct) returns the memory word at field bits [11:0] (bit 12 is ignored), with `done` in the third cycle after the start edge.
- R4: Mode 2 (double) reads the word at field bits [11:0], uses its low 12 bits as a second address and returns the word found there, with `done` in the fifth cycle after the start edge.
- R5: Mode 3 (register) returns the register chosen by the field value, where 0 selects the accumulator, 1 the B register, 6 the C register, 7 the D register and 4095 the program counter. `done` comes in the first cycle after the start edge.
- R6: Mode 4 (register pointer) returns the memory word addressed by the low 12 bits of the selected register, with `done` in the third cycle after the start edge.
- R7: In modes 3 and 4, any field value other than 0, 1, 6, 7 or 4095 gives `err`=1 and `operand`=0 with `done` in the first cycle, and no memory read is made.
- R8: Mode codes 5, 6 and 7 give `err`=1 and `operand`=0 with `done` in the first cycle after the start edge.
- R9: `busy` is high in every cycle from the one after the accepted start edge up to and including the `done` cycle. `done` lasts exactly one cycle.
- R10: A start pulse seen while `busy` is high, including in the `done` cycle, is ignored. It does not change the result or the latency, and `busy` is low in the cycle after `done`.
- R11: Each memory read holds `mem_rd_en` high for a single cycle with the address on `mem_addr`. The data is taken from `mem_rdata` one cycle later, and read-enable cycles are never adjacent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted only when idle |
| mode | input | 3 | Addressing mode code |
| field | input | 13 | Operand field of the instruction |
| reg_acc | input | 24 | Accumulator contents (code 0) |
| reg_b | input | 24 | B register contents (code 1) |
| reg_c | input | 24 | C register contents (code 6) |
| reg_d | input | 24 | D register contents (code 7) |
| reg_pc | input | 24 | Program counter contents (code 4095) |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 12 | Memory read address |
| mem_rdata | input | 24 | Memory read data, valid the cycle after the strobe |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Undefined mode or register code, qualified by `done` |
| operand | output | 24 | Resolved operand value |

## Verification
Two events can share a cycle: completion of a request (the `done` cycle) and the arrival of a new start pulse. The bench provokes this by holding `start` high, with a different mode, from the first busy cycle through the `done` cycle of a request. It then checks three things: the original result is delivered at its expected latency, the read count is unchanged, and `busy` is low in the following cycle, which shows the overlapping start was discarded and not queued.

// File: rtl/opnd_fetch.sv
module opnd_fetch #(
  parameter int DW = 24,
  parameter int FW = 13,
  parameter int AW = 12,
  parameter int MW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [MW-1:0] mode,
  input  logic [FW-1:0] field,
  input  logic [DW-1:0] reg_acc,
  input  logic [DW-1:0] reg_b,
  input  logic [DW-1:0] reg_c,
  input  logic [DW-1:0] reg_d,
  input  logic [DW-1:0] reg_pc,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] operand
);

  localparam logic [MW-1:0] M_CONST = MW'(0);
  localparam logic [MW-1:0] M_DIR   = MW'(1);
  localparam logic [MW-1:0] M_DBL   = MW'(2);
  localparam logic [MW-1:0] M_REG   = MW'(3);
  localparam logic [MW-1:0] M_RPTR  = MW'(4);
  localparam logic [FW-1:0] C_ACC = FW'(0);
  localparam logic [FW-1:0] C_B   = FW'(1);
  localparam logic [FW-1:0] C_C   = FW'(6);
  localparam logic [FW-1:0] C_D   = FW'(7);
  localparam logic [FW-1:0] C_PC  = FW'((1 << AW) - 1);

  typedef enum logic [2:0] {S_IDLE, S_ISS1, S_WAIT1, S_ISS2, S_WAIT2, S_FIN} st_t;

  st_t           st;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] op_q;
  logic          err_q;
  logic          chain_q;
  logic          reg_hit;
  logic [DW-1:0] reg_val;
  logic [DW-1:0] imm_ext;

  always_comb begin
    reg_hit = 1'b1;
    reg_val = '0;
    case (field)
      C_ACC:   reg_val = reg_acc;
      C_B:     reg_val = reg_b;
      C_C:     reg_val = reg_c;
      C_D:     reg_val = reg_d;
      C_PC:    reg_val = reg_pc;
      default: reg_hit = 1'b0;
    endcase
  end

  assign imm_ext   = {{(DW-FW){field[FW-1]}}, field};
  assign mem_rd_en = (st == S_ISS1) || (st == S_ISS2);
  assign mem_addr  = addr_q;
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign err       = err_q;
  assign operand   = op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      op_q    <= '0;
      err_q   <= 1'b0;
      chain_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          err_q <= 1'b0;
          case (mode)
            M_CONST: begin
              op_q <= imm_ext;
              st   <= S_FIN;
            end
            M_DIR, M_DBL: begin
              addr_q  <= field[AW-1:0];
              chain_q <= (mode == M_DBL);
              st      <= S_ISS1;
            end
            M_REG: begin
              op_q  <= reg_hit ? reg_val : '0;
              err_q <= !reg_hit;
              st    <= S_FIN;
            end
            M_RPTR: begin
              if (reg_hit) begin
                addr_q  <= reg_val[AW-1:0];
                chain_q <= 1'b0;
                st      <= S_ISS1;
              end else begin
                op_q  <= '0;
                err_q <= 1'b1;
                st    <= S_FIN;
              end
            end
            default: begin
              op_q  <= '0;
              err_q <= 1'b1;
              st    <= S_FIN;
            end
          endcase
        end
        S_ISS1: st <= S_WAIT1;
        S_WAIT1: begin
          if (chain_q) begin
            addr_q <= mem_rdata[AW-1:0];
            st     <= S_ISS2;
          end else begin
            op_q <= mem_rdata;
            st   <= S_FIN;
          end
        end
        S_ISS2: st <= S_WAIT2;
        S_WAIT2: begin
          op_q <= mem_rdata;
          st   <= S_FIN;
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_READ_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en); // R11
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (operand == '0)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R9
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy); // R9
  AST_CONST_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && mode == M_CONST) |=> (done && !err)); // R2
  AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && mode > M_RPTR) |=> (done && err)); // R8
  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R10

endmodule

// File: tb/opnd_fetch_test.sv
`timescale 1ns/1ps
module opnd_fetch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [12:0] field = '0;
  logic [23:0] ra, rb, rc, rd, rp;
  logic        mem_rd_en;
  logic [11:0] mem_addr;
  logic [23:0] mem_rdata;
  logic        busy, done, err;
  logic [23:0] operand;
  logic [23:0] mem [4096];
  int          n_chk = 0;
  int          n_err = 0;

  always #2 clk = ~clk;

  opnd_fetch uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .field(field),
    .reg_acc(ra), .reg_b(rb), .reg_c(rc), .reg_d(rd), .reg_pc(rp),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .err(err), .operand(operand)
  );

  function automatic logic [23:0] mval(input int i);
    return 24'(((i * 40503) ^ (i << 11)) + 1234567);
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

  task automatic chk(input bit ok, input string rq, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [23:0] regsel(input logic [12:0] c, output bit hit);
    hit = 1'b1;
    case (c)
      13'd0: return ra;
      13'd1: return rb;
      13'd6: return rc;
      13'd7: return rd;
      13'd4095: return rp;
      default: begin hit = 1'b0; return 24'h0; end
    endcase
  endfunction

  task automatic run(input logic [2:0] m, input logic [12:0] f, input logic [23:0] eop,
                     input logic eerr, input int elat, input bit pester, input string rq);
    int n = 1;
    int reads = 0;
    bit busy_ok = 1'b1;
    @(negedge clk);
    mode = m; field = f; start = 1'b1;
    @(negedge clk);
    if (pester) begin mode = 3'd0; field = 13'h0AA; end else start = 1'b0;
    while (!done && n < 8) begin
      if (!busy) busy_ok = 1'b0;
      if (mem_rd_en) reads++;
      @(negedge clk);
      n++;
    end
    if (!busy) busy_ok = 1'b0;
    chk(n == elat, {rq, " latency"}, 24'(n), 24'(elat));
    chk(operand == eop, {rq, " operand"}, operand, eop);
    chk(err == eerr, {rq, " err"}, 24'(err), 24'(eerr));
    chk(busy_ok, "R9 busy through request", 24'(busy_ok), 24'd1);
    chk(reads == (elat == 5 ? 2 : (elat == 3 ? 1 : 0)), "R11 read count", 24'(reads),
        24'(elat == 5 ? 2 : (elat == 3 ? 1 : 0)));
    @(negedge clk);
    start = 1'b0;
    if (pester) chk(!busy && !done, "R10 start in busy/done cycle ignored", 24'(busy), 24'd0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    bit hit;
    logic [23:0] v;
    for (int i = 0; i < 4096; i++) mem[i] = mval(i);
    ra = 24'h123456; rb = 24'hABCDEF; rc = 24'h800001; rd = 24'h00F00D; rp = 24'h7FFC12;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !mem_rd_en && operand == 0, "R1 reset state",
        {busy, done, err, mem_rd_en, operand[19:0]}, 24'h0);
    rst_n = 1'b1;
    // R2 constant: every field value
    for (int f = 0; f < 8192; f++) begin
      logic [12:0] ff = 13'(f);
      run(3'd0, ff, {{11{ff[12]}}, ff}, 1'b0, 1, (f % 97) == 0, "R2");
    end
    // R3 direct, bit 12 toggled and ignored
    for (int a = 0; a < 4096; a++)
      run(3'd1, {1'(a & 1), 12'(a)}, mval(a), 1'b0, 3, (a % 61) == 0, "R3");
    // R4 double read
    for (int a = 0; a < 4096; a++)
      run(3'd2, 13'(a), mval(int'(mval(a) & 24'hFFF)), 1'b0, 5, (a % 53) == 0, "R4");
    // R5 / R7 register mode over every code
    for (int c = 0; c < 8192; c++) begin
      v = regsel(13'(c), hit);
      run(3'd3, 13'(c), v, !hit, 1, (c % 89) == 0, hit ? "R5" : "R7");
    end
    // R6 register pointer with varying register contents
    for (int k = 0; k < 64; k++) begin
      ra = mval(k * 7 + 1); rb = mval(k * 7 + 2); rc = mval(k * 7 + 3);
      rd = mval(k * 7 + 4); rp = mval(k * 7 + 5);
      foreach (ra[q]) ;
      for (int s = 0; s < 5; s++) begin
        logic [12:0] code = (s == 0) ? 13'd0 : (s == 1) ? 13'd1 : (s == 2) ? 13'd6 :
                            (s == 3) ? 13'd7 : 13'd4095;
        v = regsel(code, hit);
        run(3'd4, code, mval(int'(v[11:0])), 1'b0, 3, (k % 9) == s, "R6");
      end
      run(3'd4, 13'(k + 8), 24'h0, 1'b1, 1, 1'b0, "R7");
    end
    // R8 undefined modes
    for (int m = 5; m < 8; m++)
      for (int f = 0; f < 16; f++)
        run(3'(m), 13'(f * 511), 24'h0, 1'b1, 1, f == 3, "R8");
    summary();
  end
endmodule